// File: doc/BRIEF.md
# Periodic Burst Row Refresh Controller

This block keeps a dynamic memory alive by issuing refresh bursts in which only the row strobe is pulsed. A prescaler divides the system clock into a slow timing tick. An interval counter runs on that tick, restarts itself the moment it expires, and raises a refresh request. Each request produces one burst that steps through every row address in ascending order. For each row it drives the row number on the memory address bus and holds the row strobe high for a fixed number of cycles. A short precharge gap then separates it from the next row.

The same memory bus serves a client that writes received data into the memory through a valid/ready handshake. Refresh always wins the bus. A client write that has already been accepted runs to completion first. A client that asks while a burst is pending or running is held off with ready low until the burst has finished.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset the row strobe, busy, done and the write strobe are low, ready is high, and the prescaler, interval counter and row counter start from zero.
- R2: A tick occurs once every `TICK_DIV` clocks. The first burst starts (busy and row strobe high) `TICK_DIV*INTERVAL+1` clocks after reset release. Later bursts start on a fixed grid `TICK_DIV*INTERVAL` clocks apart, whatever the burst or client activity.
- R3: A burst issues exactly `2**ROW_W` row steps, with rows 0, 1, 2 … in ascending order. During each step `mem_addr` equals the row number, so every bit above `ROW_W` is zero. `mem_addr` stays constant while the row strobe is high.
- R4: In each row step the row strobe is high for exactly `RAS_CYC` clocks and then low for exactly `GAP_CYC` clocks.
- R5: Busy is high without a break for `2**ROW_W*(RAS_CYC+GAP_CYC)` clocks. Done is high for exactly one clock, namely the first clock after busy falls.
- R6: Ready is low whenever a burst is running or a refresh is pending. A client request raised during a burst is held. Its write strobe rises in the clock after done.
- R7: A write is accepted on a clock edge where request and ready are both high. For exactly `WR_CYC` clocks afterwards, the write strobe is high and `mem_addr`/`mem_data` carry the accepted address and data.
- R8: If the refresh request arrives while a write is in progress, that write keeps its full `WR_CYC` length. The burst follows one idle clock later and takes precedence over a client request that is still waiting.
- R9: The row strobe and the write strobe are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl_req | input | 1 | Client write request |
| cl_addr | input | ADDR_W | Client write address |
| cl_data | input | DATA_W | Client write data |
| cl_ready | output | 1 | Client may be accepted at the next edge |
| mem_addr | output | ADDR_W | Memory address bus (row number during refresh) |
| mem_data | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| ras | output | 1 | Row strobe |
| busy | output | 1 | Refresh burst in progress |
| done | output | 1 | One-clock pulse at burst end |

## Verification
The bench shrinks the block so that whole bursts and several refresh periods fit in a few hundred clocks. It uses `TICK_DIV=2`, `INTERVAL=40`, `ROW_W=3` (8 rows), `RAS_CYC=2`, `GAP_CYC=1`, `WR_CYC=3` and a 12-bit address bus. With these values the complete row sweep and the 80-clock refresh grid can be checked clock by clock. They also let a client write be placed so that it is accepted on the very edge where the refresh request appears. This exercises the in-flight completion and the precedence over a waiting client, and it shows that the grid does not drift after a delayed burst.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_STROBE = 2'd1,
        SEQ_GAP   = 2'd2,
        SEQ_WRITE = 2'd3
    } seq_state_e;

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
    parameter int unsigned TICK_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (TICK_DIV <= 1) begin : g_passthru
            assign tick = 1'b1;
        end else begin : g_divide
            localparam int unsigned CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] TOP = CW'(TICK_DIV - 1);

            logic [CW-1:0] div_d, div_q;

            always_comb begin
                if (div_q == TOP) div_d = '0;
                else              div_d = div_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end

            assign tick = (div_q == TOP);
        end
    endgenerate

endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int unsigned INTERVAL = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic expire
);

    localparam int unsigned IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [IW-1:0] LAST = IW'(INTERVAL - 1);

    logic [IW-1:0] ivl_d, ivl_q;

    always_comb begin
        ivl_d = ivl_q;
        if (tick) begin
            if (ivl_q == LAST) ivl_d = '0;
            else               ivl_d = ivl_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ivl_q <= '0;
        else        ivl_q <= ivl_d;
    end

    assign expire = tick && (ivl_q == LAST);

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
    import dram_refresh_pkg::*;
#(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ROW_W   = 9,
    parameter int unsigned RAS_CYC = 2,
    parameter int unsigned GAP_CYC = 1,
    parameter int unsigned WR_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic              cl_req,
    input  logic [ADDR_W-1:0] cl_addr,
    input  logic [DATA_W-1:0] cl_data,
    output logic              cl_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_we,
    output logic              ras,
    output logic              busy,
    output logic              done
);

    localparam int unsigned MAX_CYC = (RAS_CYC > GAP_CYC) ?
                                      ((RAS_CYC > WR_CYC) ? RAS_CYC : WR_CYC) :
                                      ((GAP_CYC > WR_CYC) ? GAP_CYC : WR_CYC);
    localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RAS_END = CNT_W'(RAS_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_END = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] WR_END  = CNT_W'(WR_CYC - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = '1;

    typedef struct packed {
        seq_state_e        st;
        logic [ROW_W-1:0]  row;
        logic [CNT_W-1:0]  cnt;
        logic              pend;
        logic              done;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.pend = seq_q.pend | expire;

        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (seq_q.pend) begin
                    seq_d.st   = SEQ_STROBE;
                    seq_d.cnt  = '0;
                    seq_d.pend = expire;
                end else if (cl_req) begin
                    seq_d.st    = SEQ_WRITE;
                    seq_d.cnt   = '0;
                    seq_d.waddr = cl_addr;
                    seq_d.wdata = cl_data;
                end
            end
            SEQ_STROBE: begin
                if (seq_q.cnt == RAS_END) begin
                    seq_d.st  = SEQ_GAP;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SEQ_GAP: begin
                if (seq_q.cnt == GAP_END) begin
                    seq_d.cnt = '0;
                    if (seq_q.row == ROW_LAST) begin
                        seq_d.st   = SEQ_IDLE;
                        seq_d.row  = '0;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st  = SEQ_STROBE;
                        seq_d.row = seq_q.row + 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SEQ_WRITE: begin
                if (seq_q.cnt == WR_END) begin
                    seq_d.st  = SEQ_IDLE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st    <= SEQ_IDLE;
            seq_q.row   <= '0;
            seq_q.cnt   <= '0;
            seq_q.pend  <= 1'b0;
            seq_q.done  <= 1'b0;
            seq_q.waddr <= '0;
            seq_q.wdata <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    logic in_burst;
    assign in_burst = (seq_q.st == SEQ_STROBE) || (seq_q.st == SEQ_GAP);

    assign ras      = (seq_q.st == SEQ_STROBE);
    assign busy     = in_burst;
    assign done     = seq_q.done;
    assign mem_we   = (seq_q.st == SEQ_WRITE);
    assign cl_ready = (seq_q.st == SEQ_IDLE) && !seq_q.pend;

    always_comb begin
        mem_addr = '0;
        mem_data = '0;
        if (seq_q.st == SEQ_WRITE) begin
            mem_addr = seq_q.waddr;
            mem_data = seq_q.wdata;
        end else if (in_burst) begin
            mem_addr = ADDR_W'(seq_q.row);
        end
    end

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
    parameter int unsigned TICK_DIV = 12,
    parameter int unsigned INTERVAL = 2500,
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ROW_W    = 9,
    parameter int unsigned RAS_CYC  = 2,
    parameter int unsigned GAP_CYC  = 1,
    parameter int unsigned WR_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cl_req,
    input  logic [ADDR_W-1:0] cl_addr,
    input  logic [DATA_W-1:0] cl_data,
    output logic              cl_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_we,
    output logic              ras,
    output logic              busy,
    output logic              done
);

    logic tick;
    logic expire;

    refresh_tick_gen #(
        .TICK_DIV(TICK_DIV)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    refresh_interval_timer #(
        .INTERVAL(INTERVAL)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .expire(expire)
    );

    refresh_sequencer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ROW_W  (ROW_W),
        .RAS_CYC(RAS_CYC),
        .GAP_CYC(GAP_CYC),
        .WR_CYC (WR_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .cl_req  (cl_req),
        .cl_addr (cl_addr),
        .cl_data (cl_data),
        .cl_ready(cl_ready),
        .mem_addr(mem_addr),
        .mem_data(mem_data),
        .mem_we  (mem_we),
        .ras     (ras),
        .busy    (busy),
        .done    (done)
    );

endmodule

// File: rtl/dram_refresh_ctrl_checker.sv
module dram_refresh_ctrl_checker #(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned ROW_W   = 9,
    parameter int unsigned RAS_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic              cl_ready,
    input logic [ADDR_W-1:0] mem_addr
);

    logic [7:0] hi_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hi_len_q <= '0;
        else if (ras) hi_len_q <= hi_len_q + 1'b1;
        else          hi_len_q <= '0;
    end

    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ras && mem_we));

    a_r4_strobe_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        ras |-> busy);

    a_r4_strobe_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras && $past(ras)) |-> (hi_len_q == 8'(RAS_CYC)));

    a_r5_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_no_ready_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cl_ready);

    a_r3_first_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_addr == '0));

    a_r3_row_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras) && $past(busy)) |->
        (mem_addr[ROW_W-1:0] == ROW_W'($past(mem_addr[ROW_W-1:0]) + 1'b1)));

    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ras && $past(ras)) |-> $stable(mem_addr));

endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .ROW_W  (ROW_W),
    .RAS_CYC(RAS_CYC)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras     (ras),
    .busy    (busy),
    .done    (done),
    .mem_we  (mem_we),
    .cl_ready(cl_ready),
    .mem_addr(mem_addr)
);

// File: tb/tb_dram_refresh_ctrl.sv
module tb_dram_refresh_ctrl;

    localparam int TICK_DIV = 2;
    localparam int INTERVAL = 40;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 8;
    localparam int ROW_W    = 3;
    localparam int RAS_CYC  = 2;
    localparam int GAP_CYC  = 1;
    localparam int WR_CYC   = 3;
    localparam int ROWS     = 1 << ROW_W;
    localparam int PERIOD   = TICK_DIV * INTERVAL;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cl_req = 1'b0;
    logic [ADDR_W-1:0] cl_addr = '0;
    logic [DATA_W-1:0] cl_data = '0;
    logic              cl_ready;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;
    logic              mem_we;
    logic              ras;
    logic              busy;
    logic              done;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int last_start = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    dram_refresh_ctrl #(
        .TICK_DIV(TICK_DIV),
        .INTERVAL(INTERVAL),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ROW_W   (ROW_W),
        .RAS_CYC (RAS_CYC),
        .GAP_CYC (GAP_CYC),
        .WR_CYC  (WR_CYC)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cl_req  (cl_req),
        .cl_addr (cl_addr),
        .cl_data (cl_data),
        .cl_ready(cl_ready),
        .mem_addr(mem_addr),
        .mem_data(mem_data),
        .mem_we  (mem_we),
        .ras     (ras),
        .busy    (busy),
        .done    (done)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    task automatic wait_burst_start(output int s);
        while (!busy) @(negedge clk);
        s = cyc;
    endtask

    // Entered at the first negedge with busy high; returns one clock after done.
    task automatic walk_burst();
        for (int r = 0; r < ROWS; r++) begin
            for (int k = 0; k < RAS_CYC; k++) begin
                chk("R3 row address", mem_addr, r);
                chk("R4 strobe high", ras, 1);
                chk("R9 no write in strobe", mem_we, 0);
                chk("R6 ready low in burst", cl_ready, 0);
                @(negedge clk);
            end
            for (int k = 0; k < GAP_CYC; k++) begin
                chk("R4 strobe low in gap", ras, 0);
                chk("R5 busy through gap", busy, 1);
                @(negedge clk);
            end
        end
        chk("R5 busy falls", busy, 0);
        chk("R5 done pulse", done, 1);
        @(negedge clk);
        chk("R5 done one clock", done, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ras", ras, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 ready", cl_ready, 1);
        rst_n = 1'b1;
    endtask

    task automatic t_first_burst();
        int s;
        wait_burst_start(s);
        chk("R2 first burst start", s, PERIOD + 1);
        walk_burst();
        last_start = s;
    endtask

    task automatic t_period();
        int s;
        wait_burst_start(s);
        chk("R2 period", s - last_start, PERIOD);
        walk_burst();
        last_start = s;
    endtask

    task automatic t_client_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        cl_req = 1'b1; cl_addr = a; cl_data = d;
        while (!cl_ready) @(negedge clk);
        @(negedge clk);
        cl_req = 1'b0;
        for (int k = 0; k < WR_CYC; k++) begin
            chk("R7 write strobe", mem_we, 1);
            chk("R7 write addr", mem_addr, a);
            chk("R7 write data", mem_data, d);
            chk("R9 strobe low in write", ras, 0);
            @(negedge clk);
        end
        chk("R7 write length", mem_we, 0);
    endtask

    task automatic t_stall();
        int s;
        wait_burst_start(s);
        chk("R2 period before stall", s - last_start, PERIOD);
        repeat (3) @(negedge clk);
        cl_req = 1'b1; cl_addr = 12'h3E1; cl_data = 8'hC7;
        while (busy) begin
            chk("R6 ready held low", cl_ready, 0);
            chk("R6 no write in burst", mem_we, 0);
            @(negedge clk);
        end
        chk("R6 done cycle", done, 1);
        chk("R6 no write on done", mem_we, 0);
        @(negedge clk);
        cl_req = 1'b0;
        for (int k = 0; k < WR_CYC; k++) begin
            chk("R6 stalled write runs", mem_we, 1);
            chk("R6 stalled write addr", mem_addr, 12'h3E1);
            @(negedge clk);
        end
        chk("R6 stalled write ends", mem_we, 0);
        last_start = s;
    endtask

    task automatic t_priority();
        int nominal;
        int s2;
        nominal = last_start + PERIOD;
        while (cyc != nominal - 2) @(negedge clk);
        cl_req = 1'b1; cl_addr = 12'h5A0; cl_data = 8'h19;
        @(negedge clk);
        chk("R8 write accepted at expiry", mem_we, 1);
        for (int k = 1; k < WR_CYC; k++) begin
            @(negedge clk);
            chk("R8 write completes", mem_we, 1);
        end
        @(negedge clk);
        chk("R8 write over", mem_we, 0);
        chk("R8 waiting client refused", cl_ready, 0);
        chk("R8 burst not yet", busy, 0);
        @(negedge clk);
        chk("R8 burst wins", busy, 1);
        chk("R8 burst start cycle", cyc, nominal + WR_CYC);
        walk_burst();
        chk("R8 held client served", mem_we, 1);
        chk("R8 held client addr", mem_addr, 12'h5A0);
        cl_req = 1'b0;
        repeat (WR_CYC) @(negedge clk);
        chk("R8 held write ends", mem_we, 0);
        wait_burst_start(s2);
        chk("R2 no drift after delay", s2, nominal + PERIOD);
        walk_burst();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_first_burst();
        t_period();
        t_client_write(12'hA5C, 8'h3C);
        t_stall();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule